// File: doc/BRIEF.md
# Toggle-Bit Flash Status Decoder

This block sits on the host side of a parallel NOR flash. It finds out whether an embedded program or erase operation is still running by using the legacy toggle-polling method. After a start request it reads one status address several times through a simple request/acknowledge read port. It compares the returned words bit by bit and reports one classification: busy, done, suspended, write-buffer abort or timeout.

The data word is made of several interleaved device lanes; the default is two byte lanes, which gives a 16-bit word. Every status bit is checked in every lane. A condition counts only when all lanes show it. A flag sampled at start tells the block that a write-buffer program is in progress, which enables the abort check. Issuing the commands and the bus timing of each read belong to the surrounding logic.

Top module: `tgl_status_poller`

## Requirements
- R1: After reset `idle` is 1, `readReq` is 0 and `resValid` is 0.
- R2: A start request is taken only while `idle` is 1. It latches `statusAddr` and `wbActive`. A start request while the block is busy has no effect on the read address, the number of reads or the result.
- R3: Every read of one operation is made to the address latched at start. The first phase takes exactly three reads.
- R4: The main toggle holds when bit 6 of every lane differs between reads 1 and 2, and also between reads 2 and 3. Lane k occupies bits [8k+7:8k], and the bit numbers used here are positions within a lane.
- R5: If the main toggle holds, the write-buffer flag was set at start, and bit 1 of read 1 is set in every lane, the result code is 4 (write-buffer abort).
- R6: If the main toggle holds and bit 5 of read 1 is set in every lane, the result code is 5 (timeout). The abort check of R5 wins when both hold.
- R7: If the main toggle holds and neither R5 nor R6 applies, the result code is 1 (busy). No further reads are taken.
- R8: If the main toggle does not hold, exactly two more reads are taken, five in all. If bit 2 is the same in reads 4 and 5 in every lane, the result code is 2 (done).
- R9: If bit 2 differs between reads 4 and 5 in every lane, the result code is 3 (suspended). If it differs in only some lanes, the result code is 1 (busy).
- R10: If bit 6 toggles in only some lanes, the block treats it as no main toggle and follows R8/R9.
- R11: `resValid` is a one-cycle pulse, and `resCode` is 1 to 5 while it is high. `readReq` stays high until `readAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a status poll; taken only when idle |
| statusAddr | input | ADDR_W | Address to poll, latched at start |
| wbActive | input | 1 | A write-buffer program is in progress, latched at start |
| idle | output | 1 | Block ready for a start request |
| readReq | output | 1 | Read request, held until acknowledged |
| readAddr | output | ADDR_W | Address of the requested read |
| readAck | input | 1 | Read data valid, one cycle |
| readData | input | DEVICES*LANE_W | Returned status word |
| resValid | output | 1 | Result pulse |
| resCode | output | 3 | 1 busy, 2 done, 3 suspended, 4 abort, 5 timeout |

## Verification
The bench goes after the abort-over-timeout priority, where a swapped order would report timeout. It checks that the error bits are taken from the first read only, since a design using a later read would misreport. It also covers partial toggling across lanes: a design that ORs lanes instead of ANDing them would report busy or suspended when the lanes disagree. Start requests made mid-poll are included, to catch a design that restarts or moves the read address, and acknowledge delays are randomised to catch a design that counts reads it was never given.

// File: rtl/tgl_pkg.sv
package tgl_pkg;
  typedef enum logic [2:0] {
    RES_NONE    = 3'd0,
    RES_BUSY    = 3'd1,
    RES_DONE    = 3'd2,
    RES_SUSP    = 3'd3,
    RES_ABORT   = 3'd4,
    RES_TIMEOUT = 3'd5
  } resCode_t;

  typedef struct packed {
    logic clear;     // start accepted: latch address and flag, rewind
    logic capture;   // store the acknowledged read word
    logic emitMain;  // publish the first-phase verdict
    logic emitSusp;  // publish the second-phase verdict
  } dpCtl_t;

  localparam int MAIN_READS  = 3;
  localparam int TOTAL_READS = 5;
endpackage

// File: rtl/tgl_ctrl.sv
module tgl_ctrl
  import tgl_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   readAck,
  input  logic   mainToggle,
  output dpCtl_t ctl,
  output logic   readReq,
  output logic   idle
);
  localparam int CNT_W = $clog2(TOTAL_READS + 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_CHK_MAIN, S_CHK_SUSP} state_t;

  state_t state;
  logic [CNT_W-1:0] readCnt;

  assign idle    = (state == S_IDLE);
  assign readReq = (state == S_READ);

  always_comb begin
    ctl          = '0;
    ctl.clear    = idle && startReq;
    ctl.capture  = readReq && readAck;
    ctl.emitMain = (state == S_CHK_MAIN) && mainToggle;
    ctl.emitSusp = (state == S_CHK_SUSP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      readCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (startReq) begin
          state   <= S_READ;
          readCnt <= '0;
        end
        S_READ: if (readAck) begin
          readCnt <= readCnt + 1'b1;
          if (readCnt == CNT_W'(MAIN_READS - 1))
            state <= S_CHK_MAIN;
          else if (readCnt == CNT_W'(TOTAL_READS - 1))
            state <= S_CHK_SUSP;
        end
        S_CHK_MAIN: state <= mainToggle ? S_IDLE : S_READ;
        S_CHK_SUSP: state <= S_IDLE;
        default:    state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tgl_datapath.sv
module tgl_datapath
  import tgl_pkg::*;
#(
  parameter int DEVICES = 2,
  parameter int LANE_W  = 8,
  parameter int ADDR_W  = 26
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    ctl,
  input  logic [ADDR_W-1:0]         statusAddr,
  input  logic                      wbActive,
  input  logic [DEVICES*LANE_W-1:0] readData,
  output logic [ADDR_W-1:0]         readAddr,
  output logic                      mainToggle,
  output logic                      resValid,
  output logic [2:0]                resCode
);
  localparam int DATA_W  = DEVICES * LANE_W;
  localparam int PTR_W   = $clog2(TOTAL_READS);
  localparam int BIT_TGL = 6;
  localparam int BIT_TMO = 5;
  localparam int BIT_SUS = 2;
  localparam int BIT_ABT = 1;

  logic [DATA_W-1:0] words [TOTAL_READS];
  logic [PTR_W-1:0]  wrPtr;
  logic              wbQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readAddr <= '0;
      wbQ      <= 1'b0;
      wrPtr    <= '0;
    end else if (ctl.clear) begin
      readAddr <= statusAddr;
      wbQ      <= wbActive;
      wrPtr    <= '0;
    end else if (ctl.capture) begin
      wrPtr    <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.capture) words[wrPtr] <= readData;
  end

  logic [DEVICES-1:0] laneTgl, laneAbt, laneTmo, laneSus;

  for (genvar d = 0; d < DEVICES; d++) begin : g_lane
    localparam int B = d * LANE_W;
    assign laneTgl[d] = (words[0][B+BIT_TGL] ^ words[1][B+BIT_TGL]) &
                        (words[1][B+BIT_TGL] ^ words[2][B+BIT_TGL]);
    assign laneAbt[d] = words[0][B+BIT_ABT];
    assign laneTmo[d] = words[0][B+BIT_TMO];
    assign laneSus[d] = words[3][B+BIT_SUS] ^ words[4][B+BIT_SUS];
  end

  resCode_t codeMain, codeSusp;

  assign mainToggle = &laneTgl;

  always_comb begin
    if (wbQ && (&laneAbt))  codeMain = RES_ABORT;
    else if (&laneTmo)      codeMain = RES_TIMEOUT;
    else                    codeMain = RES_BUSY;
    if (~|laneSus)          codeSusp = RES_DONE;
    else if (&laneSus)      codeSusp = RES_SUSP;
    else                    codeSusp = RES_BUSY;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resCode  <= RES_NONE;
    end else begin
      resValid <= ctl.emitMain || ctl.emitSusp;
      if (ctl.emitMain)      resCode <= codeMain;
      else if (ctl.emitSusp) resCode <= codeSusp;
    end
  end
endmodule

// File: rtl/tgl_status_poller.sv
module tgl_status_poller
  import tgl_pkg::*;
#(
  parameter int DEVICES = 2,
  parameter int LANE_W  = 8,
  parameter int ADDR_W  = 26
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startReq,
  input  logic [ADDR_W-1:0]         statusAddr,
  input  logic                      wbActive,
  output logic                      idle,
  output logic                      readReq,
  output logic [ADDR_W-1:0]         readAddr,
  input  logic                      readAck,
  input  logic [DEVICES*LANE_W-1:0] readData,
  output logic                      resValid,
  output logic [2:0]                resCode
);
  dpCtl_t ctl;
  logic   mainToggle;

  tgl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .readAck(readAck),
    .mainToggle(mainToggle), .ctl(ctl), .readReq(readReq), .idle(idle)
  );

  tgl_datapath #(.DEVICES(DEVICES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .statusAddr(statusAddr),
    .wbActive(wbActive), .readData(readData), .readAddr(readAddr),
    .mainToggle(mainToggle), .resValid(resValid), .resCode(resCode)
  );
endmodule

// File: rtl/tgl_status_poller_chk.sv
module tgl_status_poller_chk #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              idle,
  input logic              readReq,
  input logic              readAck,
  input logic [ADDR_W-1:0] readAddr,
  input logic              resValid,
  input logic [2:0]        resCode
);
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);                                   // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && !readAck) |=> readReq);                        // R11
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resCode >= 3'd1 && resCode <= 3'd5));        // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !readReq);                                        // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !idle |=> $stable(readAddr));                              // R3
  AST_NO_RESULT_READING: assert property (@(posedge clk) disable iff (!rstN)
    readReq |-> !resValid);                                    // R11
endmodule

bind tgl_status_poller tgl_status_poller_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .idle(idle), .readReq(readReq), .readAck(readAck),
  .readAddr(readAddr), .resValid(resValid), .resCode(resCode)
);

// File: tb/tgl_status_poller_tb.sv
module tgl_status_poller_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEVICES = 2;
  localparam int LANE_W  = 8;
  localparam int ADDR_W  = 26;
  localparam int DW = DEVICES * LANE_W;

  logic clk = 0, rstN = 0;
  logic startReq = 0, wbActive = 0, readAck = 0;
  logic [ADDR_W-1:0] statusAddr = '0;
  logic [DW-1:0] readData = '0;
  logic idle, readReq, resValid;
  logic [ADDR_W-1:0] readAddr;
  logic [2:0] resCode;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tgl_status_poller #(.DEVICES(DEVICES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .statusAddr(statusAddr),
    .wbActive(wbActive), .idle(idle), .readReq(readReq), .readAddr(readAddr),
    .readAck(readAck), .readData(readData), .resValid(resValid), .resCode(resCode)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected verdict from the requirements; lanes of LANE_W bits.
  function automatic int expCode(input logic [4:0][DW-1:0] w, input bit wb,
                                 output int nReads);
    bit tgl = 1, abt = 1, tmo = 1, susAll = 1, susAny = 0;
    for (int d = 0; d < DEVICES; d++) begin
      int b = d * LANE_W;
      tgl &= (w[0][b+6] != w[1][b+6]) && (w[1][b+6] != w[2][b+6]);
      abt &= w[0][b+1];
      tmo &= w[0][b+5];
      susAll &= (w[3][b+2] != w[4][b+2]);
      susAny |= (w[3][b+2] != w[4][b+2]);
    end
    if (tgl) begin
      nReads = 3;
      if (wb && abt) return 4;
      if (tmo) return 5;
      return 1;
    end
    nReads = 5;
    if (!susAny) return 2;
    if (susAll) return 3;
    return 1;
  endfunction

  task automatic runOp(input string req, input logic [ADDR_W-1:0] a,
                       input logic [4:0][DW-1:0] w, input bit wb, input bit poke);
    int expN, n = 0, got = 0, code = 0, dly;
    int e = expCode(w, wb, expN);
    @(negedge clk);
    startReq = 1; statusAddr = a; wbActive = wb;
    @(negedge clk);
    startReq = 0; wbActive = ~wb;
    dly = $urandom_range(0, 3);
    for (int cyc = 0; cyc < 100 && got == 0; cyc++) begin
      @(negedge clk);
      if (poke && cyc == 1) begin startReq = 1; statusAddr = ~a; end
      else startReq = 0;
      if (resValid) begin got = 1; code = resCode; end
      if (readAck) readAck = 0;
      else if (readReq) begin
        if (dly == 0) begin
          check({req, " R3 read address"}, readAddr, a);
          readAck = 1; readData = (n < 5) ? w[n] : '0; n++;
          dly = $urandom_range(0, 3);
        end else dly--;
      end
    end
    startReq = 0;
    check({req, " result seen"}, got, 1);
    check({req, " result code"}, code, e);
    check({req, " R3/R8 read count"}, n, expN);
    @(negedge clk);
    check({req, " R11 pulse one cycle"}, resValid, 0);
    check({req, " R2 idle after result"}, idle, 1);
  endtask

  function automatic logic [4:0][DW-1:0] mk(input logic [DW-1:0] a, b, c, d, e);
    return {e, d, c, b, a};
  endfunction

  initial begin
    logic [4:0][DW-1:0] w;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 idle", idle, 1);
    check("R1 readReq", readReq, 0);
    check("R1 resValid", resValid, 0);
    rstN = 1;
    // R7 busy: bit6 toggles in both lanes
    runOp("R7 busy", 26'h0123, mk(16'h0000, 16'h4040, 16'h0000, 0, 0), 1, 0);
    // R5 abort: bit1 set in both lanes, flag set
    runOp("R5 abort", 26'h0456, mk(16'h0202, 16'h4242, 16'h0202, 0, 0), 1, 0);
    // R5 flag clear: abort not reported
    runOp("R5 no flag", 26'h0457, mk(16'h0202, 16'h4242, 16'h0202, 0, 0), 0, 0);
    // R6 timeout, and priority of abort over timeout
    runOp("R6 timeout", 26'h0789, mk(16'h2020, 16'h6060, 16'h2020, 0, 0), 0, 0);
    runOp("R6 abort wins", 26'h078a, mk(16'h2222, 16'h6262, 16'h2222, 0, 0), 1, 0);
    // R6 error bits only from read 1
    runOp("R6 first read only", 26'h078b, mk(16'h0000, 16'h6262, 16'h0000, 0, 0), 1, 0);
    // R8 done
    runOp("R8 done", 26'h0abc, mk(16'h0404, 16'h0404, 16'h0404, 16'h0404, 16'h0404), 0, 0);
    // R9 suspended and partial
    runOp("R9 suspended", 26'h0def, mk(0, 0, 0, 16'h0404, 16'h0000), 0, 0);
    runOp("R9 partial", 26'h0df0, mk(0, 0, 0, 16'h0004, 16'h0000), 0, 0);
    // R10 bit6 toggles in one lane only
    runOp("R10 partial toggle", 26'h0111, mk(16'h0000, 16'h0040, 16'h0000, 16'h0404, 0), 0, 0);
    // R4 toggle on only one pair of reads
    runOp("R4 half toggle", 26'h0222, mk(16'h0000, 16'h4040, 16'h4040, 0, 0), 0, 0);
    // R2 start during busy ignored
    runOp("R2 start ignored", 26'h0333, mk(0, 0, 0, 16'h0404, 0), 0, 1);
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < 5; k++) w[k] = DW'($urandom);
      if ($urandom_range(0, 1)) begin
        w[1] = w[0] ^ 16'h4040;
        w[2] = w[1] ^ 16'h4040;
      end
      if ($urandom_range(0, 2) == 0) w[4] = w[3] ^ 16'h0404;
      runOp("R4-rand", ADDR_W'($urandom), w, bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)));
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule